// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter

This block decides which pending interrupt a small 8-bit CPU should service next and gives the 16-bit address of the service vector for that source. It watches two trap strobes from the instruction decoder (an undefined-opcode trap and a software interrupt), an active-low non-maskable request line, an active-low external maskable request line, and a set of internal peripheral requests. Each peripheral request has its own enable input. The CPU supplies its current interrupt-mask bit and non-maskable-mask bit. It raises `take` on the cycle it begins the service sequence, and this acknowledges the source the arbiter has selected.

The outputs are combinational from the arbiter state and the current inputs. `pend` says that a request has won arbitration. `vec` holds the address of the vector for that source. `force_i` and `force_x` give the mask-bit values the CPU must load when it fetches the vector. The block holds a sticky arm bit for the non-maskable line. Reset sets this bit, and software can only clear it. A priority-select input lifts any one maskable source above the other maskable sources. The external maskable line can sense either a level or a falling edge.

Top module: `intr_arbiter`

## Requirements
- R1: After reset, `x_mask` is 1, `pend` is 0 and `vec` is 16'h0000 when no request is present, and a low `nmi_n` does not raise `pend`.
- R2: A one-cycle `x_clear` pulse clears `x_mask` at the next clock edge. After that, no input other than `rst` can set it again, and taking a non-maskable interrupt does not set it either.
- R3: A low `nmi_n` is pending only while `x_mask` is 0 and `cpu_x` is 0. It selects vector 16'hFFF4, drives `force_x` and `force_i` to 1, and outranks every maskable source.
- R4: The trap order is fixed: the undefined-opcode trap (vector 16'hFFF8) first, then the software interrupt (16'hFFF6), then the non-maskable request. Both traps are served whatever the value of `cpu_i`. A trap drives `force_i` to 1 and `force_x` to 0.
- R5: While `cpu_i` is 1, no maskable source is pending. Peripheral k requests only while `periph_en[k]` is 1.
- R6: The maskable group is indexed with the external line as index 0 and peripheral k as index k+1. Lower indices win. Index n uses vector 16'hFFF2 - 2n, so peripheral 0 uses 16'hFFF0. A maskable win drives `force_i` to 1 and `force_x` to 0.
- R7: When `prio_sel` equals a valid index n, source n outranks all other maskable sources, and the remaining sources keep their index order. A `prio_sel` value of NPERIPH+1 or more promotes nothing.
- R8: While `irq_edge_mode` is 0, the external request is simply the current level of `ext_irq_n` inverted. It is not stored, so it appears and disappears in the same cycle as the line.
- R9: While `irq_edge_mode` is 1, a falling edge of `ext_irq_n` (sampled high at one clock edge and low at the next) stores a request. The stored request stays pending after the line returns high, and it clears only at a clock edge where `take` is 1 and the external source is selected.
- R10: A one-cycle `swi_stb` or `illop_stb` stores a pending trap from the next edge onward. The trap stays stored until a clock edge where `take` is 1 and that trap is selected. A new strobe in that same cycle keeps the trap stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq_n | input | 1 | External maskable request, active low |
| irq_edge_mode | input | 1 | 1 selects falling-edge sensing of the external line |
| nmi_n | input | 1 | Non-maskable request, active low |
| swi_stb | input | 1 | Software-interrupt strobe |
| illop_stb | input | 1 | Undefined-opcode trap strobe |
| periph_req | input | NPERIPH | Peripheral requests |
| periph_en | input | NPERIPH | Per-peripheral enables |
| prio_sel | input | SELW | Index of the promoted maskable source |
| cpu_i | input | 1 | CPU maskable-interrupt mask bit |
| cpu_x | input | 1 | CPU non-maskable mask bit |
| x_clear | input | 1 | Software clear of the non-maskable arm bit |
| take | input | 1 | CPU acknowledges the selected source |
| pend | output | 1 | A source has won arbitration |
| vec | output | 16 | Vector address of the winner, 0 when idle |
| force_i | output | 1 | Value to load into I at vector fetch |
| force_x | output | 1 | Value to load into X at vector fetch |
| x_mask | output | 1 | Sticky non-maskable arm bit, 1 = blocked |

## Verification
The properties checked on every cycle cover the following behaviour. The arm bit never comes back to 1 after it has been cleared. A non-maskable win never occurs while either of its masks is set, and a maskable win never occurs while `cpu_i` is set. The forced mask bits always match the class of the winner. A trap strobe always makes its vector visible on the following cycle. The bench scenarios show the orderings that depend on several sources being pending at once: promotion combined with the fixed order, edge storage across a release of the line, acknowledgement clearing only the selected source, and reset being the only way to re-arm the non-maskable mask.

// File: rtl/intr_arb_pkg.sv
package intr_arb_pkg;

    localparam int IDXW = 8;

    localparam logic [15:0] VEC_ILLOP = 16'hFFF8;
    localparam logic [15:0] VEC_SWI   = 16'hFFF6;
    localparam logic [15:0] VEC_NMI   = 16'hFFF4;
    localparam logic [15:0] VEC_EXT   = 16'hFFF2;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_ILLOP,
        SRC_SWI,
        SRC_NMI,
        SRC_MASK
    } src_kind_e;

    typedef struct packed {
        src_kind_e        kind;
        logic [IDXW-1:0]  idx;
    } arb_pick_t;

    typedef struct packed {
        logic ext;
        logic swi;
        logic illop;
    } ack_t;

    // maskable index n sits two bytes below index n-1
    function automatic logic [15:0] mask_vector(input logic [IDXW-1:0] idx);
        return VEC_EXT - (16'(idx) << 1);
    endfunction

    function automatic logic [15:0] pick_vector(input arb_pick_t p);
        case (p.kind)
            SRC_ILLOP: return VEC_ILLOP;
            SRC_SWI:   return VEC_SWI;
            SRC_NMI:   return VEC_NMI;
            SRC_MASK:  return mask_vector(p.idx);
            default:   return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/intr_src_latch.sv
module intr_src_latch
    import intr_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ext_irq_n,
    input  logic edge_mode,
    input  logic swi_stb,
    input  logic illop_stb,
    input  ack_t ack,
    output logic ext_req,
    output logic swi_pend,
    output logic illop_pend
);

    logic line_prev_q;
    logic edge_q;
    logic fall;

    assign fall = line_prev_q & ~ext_irq_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_prev_q <= 1'b1;
            edge_q      <= 1'b0;
            swi_pend    <= 1'b0;
            illop_pend  <= 1'b0;
        end else begin
            line_prev_q <= ext_irq_n;
            if (!edge_mode)
                edge_q <= 1'b0;
            else
                edge_q <= (edge_q & ~ack.ext) | fall;
            swi_pend   <= (swi_pend & ~ack.swi) | swi_stb;
            illop_pend <= (illop_pend & ~ack.illop) | illop_stb;
        end
    end

    assign ext_req = edge_mode ? edge_q : ~ext_irq_n;

endmodule

// File: rtl/intr_mask_prio.sv
module intr_mask_prio #(
    parameter int NMASK = 5,
    parameter int SELW  = 3
) (
    input  logic [NMASK-1:0] req,
    input  logic [SELW-1:0]  prio_sel,
    output logic             found,
    output logic [SELW-1:0]  idx
);

    logic [NMASK-1:0] promo_hit;
    logic             promo_any;
    logic [SELW-1:0]  promo_idx;
    logic             base_found;
    logic [SELW-1:0]  base_idx;

    genvar g;
    generate
        for (g = 0; g < NMASK; g++) begin : g_hit
            assign promo_hit[g] = req[g] && (prio_sel == SELW'(g));
        end
    endgenerate

    always_comb begin
        promo_any = 1'b0;
        promo_idx = '0;
        for (int i = 0; i < NMASK; i++) begin
            if (promo_hit[i]) begin
                promo_any = 1'b1;
                promo_idx = SELW'(i);
            end
        end
    end

    always_comb begin
        base_found = 1'b0;
        base_idx   = '0;
        for (int i = NMASK - 1; i >= 0; i--) begin
            if (req[i]) begin
                base_found = 1'b1;
                base_idx   = SELW'(i);
            end
        end
    end

    assign found = base_found;
    assign idx   = promo_any ? promo_idx : base_idx;

endmodule

// File: rtl/intr_pick.sv
module intr_pick
    import intr_arb_pkg::*;
(
    input  logic             illop_pend,
    input  logic             swi_pend,
    input  logic             nmi_req,
    input  logic             mask_found,
    input  logic [IDXW-1:0]  mask_idx,
    output arb_pick_t        pick
);

    always_comb begin
        pick.idx = '0;
        if (illop_pend) begin
            pick.kind = SRC_ILLOP;
        end else if (swi_pend) begin
            pick.kind = SRC_SWI;
        end else if (nmi_req) begin
            pick.kind = SRC_NMI;
        end else if (mask_found) begin
            pick.kind = SRC_MASK;
            pick.idx  = mask_idx;
        end else begin
            pick.kind = SRC_NONE;
        end
    end

endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
    import intr_arb_pkg::*;
#(
    parameter int NPERIPH = 4,
    parameter int SELW    = $clog2(NPERIPH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ext_irq_n,
    input  logic               irq_edge_mode,
    input  logic               nmi_n,
    input  logic               swi_stb,
    input  logic               illop_stb,
    input  logic [NPERIPH-1:0] periph_req,
    input  logic [NPERIPH-1:0] periph_en,
    input  logic [SELW-1:0]    prio_sel,
    input  logic               cpu_i,
    input  logic               cpu_x,
    input  logic               x_clear,
    input  logic               take,
    output logic               pend,
    output logic [15:0]        vec,
    output logic               force_i,
    output logic               force_x,
    output logic               x_mask
);

    localparam int NMASK = NPERIPH + 1;

    logic             x_q;
    logic             ext_req;
    logic             swi_pend;
    logic             illop_pend;
    logic             nmi_req;
    logic [NMASK-1:0] mask_raw;
    logic [NMASK-1:0] mask_live;
    logic             mask_found;
    logic [SELW-1:0]  mask_idx;
    arb_pick_t        pick;
    ack_t             ack;

    // sticky arm bit: only reset sets it
    always_ff @(posedge clk) begin
        if (rst)
            x_q <= 1'b1;
        else if (x_clear)
            x_q <= 1'b0;
    end

    intr_src_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .ext_irq_n  (ext_irq_n),
        .edge_mode  (irq_edge_mode),
        .swi_stb    (swi_stb),
        .illop_stb  (illop_stb),
        .ack        (ack),
        .ext_req    (ext_req),
        .swi_pend   (swi_pend),
        .illop_pend (illop_pend)
    );

    assign mask_raw[0] = ext_req;
    genvar g;
    generate
        for (g = 0; g < NPERIPH; g++) begin : g_periph
            assign mask_raw[g+1] = periph_req[g] & periph_en[g];
        end
    endgenerate

    assign mask_live = mask_raw & {NMASK{~cpu_i}};
    assign nmi_req   = ~nmi_n & ~x_q & ~cpu_x;

    intr_mask_prio #(.NMASK(NMASK), .SELW(SELW)) u_prio (
        .req      (mask_live),
        .prio_sel (prio_sel),
        .found    (mask_found),
        .idx      (mask_idx)
    );

    intr_pick u_pick (
        .illop_pend (illop_pend),
        .swi_pend   (swi_pend),
        .nmi_req    (nmi_req),
        .mask_found (mask_found),
        .mask_idx   (IDXW'(mask_idx)),
        .pick       (pick)
    );

    assign ack.illop = take && (pick.kind == SRC_ILLOP);
    assign ack.swi   = take && (pick.kind == SRC_SWI);
    assign ack.ext   = take && (pick.kind == SRC_MASK) && (pick.idx == '0);

    assign pend    = (pick.kind != SRC_NONE);
    assign vec     = pick_vector(pick);
    assign force_i = pend;
    assign force_x = (pick.kind == SRC_NMI);
    assign x_mask  = x_q;

endmodule

// File: rtl/intr_arbiter_chk.sv
module intr_arbiter_chk (
    input logic        clk,
    input logic        rst,
    input logic        illop_stb,
    input logic        swi_stb,
    input logic        cpu_i,
    input logic        cpu_x,
    input logic        pend,
    input logic [15:0] vec,
    input logic        force_i,
    input logic        force_x,
    input logic        x_mask
);

    p_xmask_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        !x_mask |=> !x_mask);

    p_nmi_gated_r3: assert property (@(posedge clk) disable iff (rst)
        (pend && vec == 16'hFFF4) |-> (!x_mask && !cpu_x));

    p_nmi_force_r3: assert property (@(posedge clk) disable iff (rst)
        (pend && vec == 16'hFFF4) |-> (force_x && force_i));

    p_xforce_only_nmi_r3: assert property (@(posedge clk) disable iff (rst)
        force_x |-> (vec == 16'hFFF4));

    p_illop_next_r4: assert property (@(posedge clk) disable iff (rst)
        illop_stb |=> (pend && vec == 16'hFFF8));

    p_swi_next_r10: assert property (@(posedge clk) disable iff (rst)
        swi_stb |=> (pend && (vec == 16'hFFF6 || vec == 16'hFFF8)));

    p_mask_blocked_r5: assert property (@(posedge clk) disable iff (rst)
        (pend && vec < 16'hFFF4) |-> !cpu_i);

    p_force_i_r6: assert property (@(posedge clk) disable iff (rst)
        pend |-> force_i);

endmodule

bind intr_arbiter intr_arbiter_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .illop_stb (illop_stb),
    .swi_stb   (swi_stb),
    .cpu_i     (cpu_i),
    .cpu_x     (cpu_x),
    .pend      (pend),
    .vec       (vec),
    .force_i   (force_i),
    .force_x   (force_x),
    .x_mask    (x_mask)
);

// File: tb/intr_arbiter_bench.sv
module intr_arbiter_bench;

    localparam int CLK_P   = 10;
    localparam int NPERIPH = 4;
    localparam int SELW    = $clog2(NPERIPH + 1);

    logic               clk = 1'b0;
    logic               rst;
    logic               ext_irq_n;
    logic               irq_edge_mode;
    logic               nmi_n;
    logic               swi_stb;
    logic               illop_stb;
    logic [NPERIPH-1:0] periph_req;
    logic [NPERIPH-1:0] periph_en;
    logic [SELW-1:0]    prio_sel;
    logic               cpu_i;
    logic               cpu_x;
    logic               x_clear;
    logic               take;
    logic               pend;
    logic [15:0]        vec;
    logic               force_i;
    logic               force_x;
    logic               x_mask;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    intr_arbiter #(.NPERIPH(NPERIPH)) u_intr_arbiter (
        .clk(clk), .rst(rst), .ext_irq_n(ext_irq_n), .irq_edge_mode(irq_edge_mode),
        .nmi_n(nmi_n), .swi_stb(swi_stb), .illop_stb(illop_stb),
        .periph_req(periph_req), .periph_en(periph_en), .prio_sel(prio_sel),
        .cpu_i(cpu_i), .cpu_x(cpu_x), .x_clear(x_clear), .take(take),
        .pend(pend), .vec(vec), .force_i(force_i), .force_x(force_x), .x_mask(x_mask)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ext_irq_n = 1'b1; irq_edge_mode = 1'b0; nmi_n = 1'b1;
        swi_stb = 1'b0; illop_stb = 1'b0; periph_req = '0; periph_en = '1;
        prio_sel = '1; cpu_i = 1'b1; cpu_x = 1'b0; x_clear = 1'b0; take = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic pulse_take();
        @(negedge clk); take = 1'b1;
        @(negedge clk); take = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 x_mask", x_mask, 1);
        chk("R1 pend idle", pend, 0);
        chk("R1 vec idle", vec, 0);
        nmi_n = 1'b0; #1;
        chk("R1 nmi ignored", pend, 0);
    endtask

    task automatic t_nmi();
        do_reset();
        nmi_n = 1'b0; cpu_i = 1'b0; ext_irq_n = 1'b0;
        @(negedge clk); x_clear = 1'b1;
        @(negedge clk); x_clear = 1'b0; #1;
        chk("R2 x cleared", x_mask, 0);
        chk("R3 nmi vec beats maskable", vec, 32'hFFF4);
        chk("R3 force_x", force_x, 1);
        chk("R3 force_i", force_i, 1);
        cpu_x = 1'b1; #1;
        chk("R3 cpu_x blocks nmi", vec, 32'hFFF2);
        cpu_x = 1'b0;
        pulse_take();
        repeat (3) @(negedge clk);
        #1;
        chk("R2 take does not rearm", x_mask, 0);
        do_reset();
        chk("R2 reset rearms", x_mask, 1);
    endtask

    task automatic t_traps();
        do_reset();
        @(negedge clk); x_clear = 1'b1; nmi_n = 1'b0;
        @(negedge clk); x_clear = 1'b0; swi_stb = 1'b1;
        @(negedge clk); swi_stb = 1'b0; #1;
        chk("R10 swi stored", vec, 32'hFFF6);
        chk("R4 swi force_x", force_x, 0);
        chk("R4 swi force_i with cpu_i=1", force_i, 1);
        @(negedge clk); illop_stb = 1'b1;
        @(negedge clk); illop_stb = 1'b0; #1;
        chk("R4 illop over swi", vec, 32'hFFF8);
        pulse_take();
        chk("R10 ack illop keeps swi", vec, 32'hFFF6);
        pulse_take();
        chk("R4 nmi after traps", vec, 32'hFFF4);
        @(negedge clk); swi_stb = 1'b1; take = 1'b1;
        @(negedge clk); swi_stb = 1'b0; take = 1'b0; #1;
        chk("R10 strobe wins over ack", vec, 32'hFFF6);
    endtask

    task automatic t_mask_order();
        do_reset();
        periph_req = 4'b0101; #1;
        chk("R5 cpu_i blocks", pend, 0);
        cpu_i = 1'b0; #1;
        chk("R6 periph0 first", vec, 32'hFFF0);
        chk("R6 force_x maskable", force_x, 0);
        periph_en[0] = 1'b0; #1;
        chk("R5 enable gates periph0", vec, 32'hFFEC);
        periph_req = 4'b0001; #1;
        chk("R5 disabled only", pend, 0);
        periph_en = '1; periph_req = 4'b1000; ext_irq_n = 1'b0; #1;
        chk("R6 ext over periph", vec, 32'hFFF2);
        ext_irq_n = 1'b1; #1;
        chk("R6 periph3 vector", vec, 32'hFFEA);
    endtask

    task automatic t_promote();
        do_reset();
        cpu_i = 1'b0; ext_irq_n = 1'b0; periph_req = 4'b0101;
        prio_sel = 3'd3; #1;
        chk("R7 promoted periph2", vec, 32'hFFEC);
        periph_req = 4'b0001; #1;
        chk("R7 rest keeps order", vec, 32'hFFF2);
        ext_irq_n = 1'b1; periph_req = 4'b1010; prio_sel = 3'd4; #1;
        chk("R7 promoted periph3", vec, 32'hFFEA);
        prio_sel = 3'd7; #1;
        chk("R7 out of range", vec, 32'hFFEE);
    endtask

    task automatic t_level();
        do_reset();
        cpu_i = 1'b0;
        @(negedge clk); ext_irq_n = 1'b0; #1;
        chk("R8 level same cycle", vec, 32'hFFF2);
        pulse_take();
        chk("R8 level held after take", pend, 1);
        ext_irq_n = 1'b1; #1;
        chk("R8 release drops", pend, 0);
    endtask

    task automatic t_edge();
        do_reset();
        cpu_i = 1'b0; irq_edge_mode = 1'b1;
        @(negedge clk); ext_irq_n = 1'b0; #1;
        chk("R9 not yet stored", pend, 0);
        @(posedge clk); #1;
        chk("R9 edge stored", vec, 32'hFFF2);
        @(negedge clk); ext_irq_n = 1'b1; #1;
        chk("R9 held after release", pend, 1);
        periph_req = 4'b0010; prio_sel = 3'd2;
        pulse_take();
        chk("R9 ack other keeps ext", pend, 1);
        periph_req = '0; prio_sel = '1; #1;
        chk("R9 ext still stored", vec, 32'hFFF2);
        pulse_take();
        chk("R9 ack clears", pend, 0);
    endtask

    initial begin
        #(CLK_P * 20000);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_nmi();
        t_traps();
        t_mask_order();
        t_promote();
        t_level();
        t_edge();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule